// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block watches the received byte stream behind an Ethernet MAC and decides, per frame, whether the frame is kept or dropped. It compares the destination address with a programmed station address and recognises broadcast. It applies promiscuous and broadcast-reject policy. It can suppress reception while the local transmitter is busy. It also counts every frame byte from the first destination-address byte through the last CRC byte and raises an interrupt when a frame grows past a programmable maximum length.

Two results come out for each frame. An early verdict appears once the destination address is complete. A status word appears with the end of the frame and carries the accept bit, a long-frame bit and a miss bit. The miss bit marks a frame that promiscuous mode let through although normal matching would have refused it. Configuration is captured into shadow registers only while the block is disabled, so the policy cannot change in the middle of a frame.

Top module: `rxf_accept_filter`

## Requirements
- R1: After synchronous reset, every output (dec_valid, dec_accept, dec_miss, stat_valid, stat_accept, stat_long, stat_miss, babble_irq) is 0.
- R2: Configuration inputs are copied on every clock edge at which `enable` is low. Changes to them while `enable` is high have no effect on filtering or length checks.
- R3: A frame begins with a byte that has `in_valid` and `in_sof` high, and ends with the byte that has `in_eof` high. Both markers may sit on one byte. Valid bytes that arrive outside a frame are ignored. The length is the count of bytes from the start byte through the end byte, inclusive.
- R4: When the byte count first exceeds `cfg_max_len`, `babble_irq` is high for exactly one cycle, one cycle after that byte. This happens at most once per frame. That frame's status has `stat_long` = 1.
- R5: Without promiscuous mode, a frame is accepted when its six destination bytes equal the station address, compared in arrival order. The first byte is matched against `cfg_station_mac[47:40]` and the sixth against `cfg_station_mac[7:0]`.
- R6: A frame whose destination is all ones (FF on all six bytes) is accepted when broadcast reject is 0. It is dropped when broadcast reject is 1 and promiscuous is 0.
- R7: With promiscuous mode set, every non-gated frame that reaches six bytes is accepted. The miss bit is 1 exactly when normal matching (R5, R6) would have dropped it. This includes a broadcast frame with broadcast reject set.
- R8: A group address that matches neither the station address nor broadcast (first byte bit 0 set) is dropped unless promiscuous mode is set.
- R9: When disable-receive-on-transmit is 1, loopback is 0, and `tx_active` is high on the start byte, the whole frame is dropped. Its verdict and status report accept 0 and miss 0, its status reports long 0, and it raises no interrupt.
- R10: With loopback set, disable-receive-on-transmit is treated as 0, so `tx_active` has no effect.
- R11: `dec_valid` pulses once per frame. It comes one cycle after the sixth byte, or one cycle after the end byte when the frame has fewer than six bytes. Such a short frame is always dropped.
- R12: `stat_valid` pulses one cycle after the end byte. It carries the accept and miss values of the verdict and the long-frame bit of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | High: filter frames; low: reload configuration and idle |
| cfg_max_len | input | LEN_W | Largest allowed frame length in bytes |
| cfg_bc_reject | input | 1 | Refuse broadcast destinations |
| cfg_promisc | input | 1 | Accept all frames |
| cfg_no_rx_on_tx | input | 1 | Drop frames that start while transmitting |
| cfg_loopback | input | 1 | Loopback active; cancels cfg_no_rx_on_tx |
| cfg_station_mac | input | 8*ADDR_BYTES | Station address, first byte in the top bits |
| tx_active | input | 1 | Local transmitter busy |
| in_valid | input | 1 | Byte present on in_data |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| dec_valid | output | 1 | Early verdict strobe |
| dec_accept | output | 1 | Early verdict: keep frame |
| dec_miss | output | 1 | Early verdict: kept only by promiscuous mode |
| stat_valid | output | 1 | End-of-frame status strobe |
| stat_accept | output | 1 | Status: frame kept |
| stat_long | output | 1 | Status: frame exceeded maximum length |
| stat_miss | output | 1 | Status: kept only by promiscuous mode |
| babble_irq | output | 1 | One-cycle oversize interrupt |

## Verification
The assertions take for granted that every input is driven to a known level from the first clock edge. They also assume that `enable` is low for at least one edge before frames arrive, so that the shadow registers hold real settings. The single-pulse interrupt property allows for a new frame starting on the very next byte, because a zero or tiny maximum length could make that frame trip at once. The stimulus uses a maximum of twelve bytes and only sends bytes with `enable` high. It changes configuration pins with `enable` low, except in the one hold test, where the effect of a change made while enabled is the thing being checked.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef struct packed {
    logic bc_reject;
    logic promisc;
    logic no_rx_on_tx;
    logic loopback;
  } rxf_mode_t;

  typedef struct packed {
    logic accept;
    logic miss;
  } rxf_verdict_t;

  // Loopback cancels the transmit gate.
  function automatic logic rxf_gate_en(rxf_mode_t m);
    return m.no_rx_on_tx & ~m.loopback;
  endfunction

  // Address policy for a frame whose destination is complete.
  function automatic rxf_verdict_t rxf_judge(rxf_mode_t m, logic hit, logic bcast);
    rxf_verdict_t v;
    logic normal_ok;
    normal_ok = hit | (bcast & ~m.bc_reject);
    v.accept  = m.promisc | normal_ok;
    v.miss    = m.promisc & ~normal_ok;
    return v;
  endfunction

endpackage

// File: rtl/rxf_cfg_shadow.sv
module rxf_cfg_shadow
  import rxf_pkg::*;
#(
  parameter int LEN_W       = 14,
  parameter int MAC_W       = 48,
  parameter int DEF_MAX_LEN = 1518
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [LEN_W-1:0] max_len_in,
  input  rxf_mode_t        mode_in,
  input  logic [MAC_W-1:0] mac_in,
  output logic [LEN_W-1:0] max_len_q,
  output rxf_mode_t        mode_q,
  output logic [MAC_W-1:0] mac_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      max_len_q <= LEN_W'(DEF_MAX_LEN);
      mode_q    <= '0;
      mac_q     <= '0;
    end else if (!enable) begin
      max_len_q <= max_len_in;
      mode_q    <= mode_in;
      mac_q     <= mac_in;
    end
  end

  // R2: settings frozen while the filter runs
  a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (enable && $past(enable)) |-> ($stable(max_len_q) && $stable(mode_q) && $stable(mac_q)));

endmodule

// File: rtl/rxf_len_track.sv
module rxf_len_track #(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             start,
  input  logic             blocked,
  input  logic [LEN_W-1:0] max_len,
  output logic             long_now,
  output logic             irq
);

  logic [LEN_W-1:0] cnt_q, cnt_nx;
  logic             long_q, long_prev, over;
  logic             irq_q;

  always_comb begin
    if (start)             cnt_nx = LEN_W'(1);
    else if (cnt_q == '1)  cnt_nx = cnt_q;
    else                   cnt_nx = cnt_q + 1'b1;
    over      = cnt_nx > max_len;
    long_prev = start ? 1'b0 : long_q;
    long_now  = long_prev | (over & ~blocked);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= take & over & ~blocked & ~long_prev;
      if (take) begin
        cnt_q  <= cnt_nx;
        long_q <= long_now;
      end
    end
  end

  assign irq = irq_q;

  // R4: a pulse never stretches inside one frame
  a_r4_irq_single: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !(take && start)) |=> !irq_q);

  // R4: the pulse coincides with the sticky long flag being set
  a_r4_irq_sets_long: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> long_q);

endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  localparam int MAC_W     = 8 * ADDR_BYTES,
  localparam int IDX_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             start,
  input  logic             eof,
  input  logic             blocked,
  input  logic [7:0]       data,
  input  logic [MAC_W-1:0] mac,
  input  rxf_mode_t        mode,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic             dec_miss,
  output logic             fr_accept,
  output logic             fr_miss
);

  logic [7:0]       mac_b [ADDR_BYTES];
  logic [7:0]       mac_sel;
  logic [IDX_W-1:0] idx_q, pos;
  logic             hit_q, ones_q, hit_nx, ones_nx;
  logic             in_da, last, runt_end;
  logic             acc_q, miss_q, acc_now, miss_now;
  logic             dv_q, da_q, dm_q;
  rxf_verdict_t     v;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_mac_bytes
    assign mac_b[g] = mac[MAC_W-1-8*g -: 8];
  end

  always_comb begin
    pos   = start ? '0 : idx_q;
    in_da = pos < IDX_W'(ADDR_BYTES);
    mac_sel = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (pos == IDX_W'(i)) mac_sel = mac_b[i];
    hit_nx   = ((pos == '0) ? 1'b1 : hit_q)  & (data == mac_sel);
    ones_nx  = ((pos == '0) ? 1'b1 : ones_q) & (&data);
    last     = take & (pos == IDX_W'(ADDR_BYTES - 1));
    runt_end = take & eof & (pos < IDX_W'(ADDR_BYTES - 1));
    v        = rxf_judge(mode, hit_nx, ones_nx);
    acc_now  = v.accept & ~blocked;
    miss_now = v.miss & ~blocked;
    fr_accept = last ? acc_now  : (start ? 1'b0 : acc_q);
    fr_miss   = last ? miss_now : (start ? 1'b0 : miss_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      hit_q  <= 1'b0;
      ones_q <= 1'b0;
      acc_q  <= 1'b0;
      miss_q <= 1'b0;
      dv_q   <= 1'b0;
      da_q   <= 1'b0;
      dm_q   <= 1'b0;
    end else begin
      dv_q <= last | runt_end;
      da_q <= last & acc_now;
      dm_q <= last & miss_now;
      if (take) begin
        idx_q <= in_da ? pos + 1'b1 : pos;
        if (in_da) begin
          hit_q  <= hit_nx;
          ones_q <= ones_nx;
        end
        if (last) begin
          acc_q  <= acc_now;
          miss_q <= miss_now;
        end else if (start) begin
          acc_q  <= 1'b0;
          miss_q <= 1'b0;
        end
      end
    end
  end

  assign dec_valid  = dv_q;
  assign dec_accept = da_q;
  assign dec_miss   = dm_q;

  // R11: a verdict bit only travels with its strobe
  a_r11_accept_with_strobe: assert property (@(posedge clk) disable iff (rst)
    dec_accept |-> dec_valid);

  // R7: miss appears only on promiscuous acceptances
  a_r7_miss_needs_promisc: assert property (@(posedge clk) disable iff (rst)
    dec_miss |-> (dec_accept && mode.promisc));

endmodule

// File: rtl/rxf_accept_filter.sv
module rxf_accept_filter
  import rxf_pkg::*;
#(
  parameter int LEN_W       = 14,
  parameter int ADDR_BYTES  = 6,
  parameter int DEF_MAX_LEN = 1518,
  localparam int MAC_W      = 8 * ADDR_BYTES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [LEN_W-1:0] cfg_max_len,
  input  logic             cfg_bc_reject,
  input  logic             cfg_promisc,
  input  logic             cfg_no_rx_on_tx,
  input  logic             cfg_loopback,
  input  logic [MAC_W-1:0] cfg_station_mac,
  input  logic             tx_active,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic             dec_miss,
  output logic             stat_valid,
  output logic             stat_accept,
  output logic             stat_long,
  output logic             stat_miss,
  output logic             babble_irq
);

  rxf_mode_t        mode_in, mode_q;
  logic [LEN_W-1:0] max_len_q;
  logic [MAC_W-1:0] mac_q;
  logic             in_frame_q, blocked_q, blk_now;
  logic             start, take;
  logic             long_now, fr_accept, fr_miss;
  logic             sv_q, sa_q, sl_q, sm_q;

  assign mode_in = '{bc_reject:   cfg_bc_reject,
                     promisc:     cfg_promisc,
                     no_rx_on_tx: cfg_no_rx_on_tx,
                     loopback:    cfg_loopback};

  rxf_cfg_shadow #(
    .LEN_W(LEN_W), .MAC_W(MAC_W), .DEF_MAX_LEN(DEF_MAX_LEN)
  ) u_cfg (
    .clk(clk), .rst(rst), .enable(enable),
    .max_len_in(cfg_max_len), .mode_in(mode_in), .mac_in(cfg_station_mac),
    .max_len_q(max_len_q), .mode_q(mode_q), .mac_q(mac_q)
  );

  assign start   = enable & in_valid & in_sof;
  assign take    = enable & in_valid & (in_sof | in_frame_q);
  assign blk_now = start ? (rxf_gate_en(mode_q) & tx_active) : blocked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q <= 1'b0;
      blocked_q  <= 1'b0;
    end else begin
      if (!enable)   in_frame_q <= 1'b0;
      else if (take) in_frame_q <= ~in_eof;
      if (start) blocked_q <= blk_now;
    end
  end

  rxf_len_track #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .take(take), .start(start), .blocked(blk_now),
    .max_len(max_len_q), .long_now(long_now), .irq(babble_irq)
  );

  rxf_addr_match #(.ADDR_BYTES(ADDR_BYTES)) u_addr (
    .clk(clk), .rst(rst), .take(take), .start(start), .eof(in_eof),
    .blocked(blk_now), .data(in_data), .mac(mac_q), .mode(mode_q),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_miss(dec_miss),
    .fr_accept(fr_accept), .fr_miss(fr_miss)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sv_q <= 1'b0;
      sa_q <= 1'b0;
      sl_q <= 1'b0;
      sm_q <= 1'b0;
    end else begin
      sv_q <= take & in_eof;
      sa_q <= take & in_eof & fr_accept;
      sl_q <= take & in_eof & long_now;
      sm_q <= take & in_eof & fr_miss;
    end
  end

  assign stat_valid  = sv_q;
  assign stat_accept = sa_q;
  assign stat_long   = sl_q;
  assign stat_miss   = sm_q;

  // R9: a gated frame reports nothing but a drop
  a_r9_gated_status: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && blocked_q) |-> (!stat_accept && !stat_long && !stat_miss));

  a_r9_gated_verdict: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && blocked_q) |-> !dec_accept);

  // R12: status follows the end byte, so the frame is closed
  a_r12_status_closes: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> !in_frame_q);

endmodule

// File: tb/rxf_accept_filter_tb.sv
`timescale 1ns/1ps
module rxf_accept_filter_tb;
  localparam int LEN_W = 14;
  localparam int AB    = 6;
  localparam logic [47:0] STATION = 48'h021A_3344_5566;
  localparam logic [47:0] OTHER   = 48'h021A_3344_5567;
  localparam logic [47:0] GROUP   = 48'h0100_5E00_0001;
  localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;

  logic clk = 1'b0, rst = 1'b1, enable = 1'b0;
  logic [LEN_W-1:0] cfg_max_len = '0;
  logic cfg_bc_reject = 0, cfg_promisc = 0, cfg_no_rx_on_tx = 0, cfg_loopback = 0;
  logic [47:0] cfg_station_mac = STATION;
  logic tx_active = 0, in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = '0;
  logic dec_valid, dec_accept, dec_miss, stat_valid, stat_accept, stat_long, stat_miss, babble_irq;

  always #2.5 clk = ~clk;

  rxf_accept_filter #(.LEN_W(LEN_W), .ADDR_BYTES(AB)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .cfg_max_len(cfg_max_len),
    .cfg_bc_reject(cfg_bc_reject), .cfg_promisc(cfg_promisc),
    .cfg_no_rx_on_tx(cfg_no_rx_on_tx), .cfg_loopback(cfg_loopback),
    .cfg_station_mac(cfg_station_mac), .tx_active(tx_active),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_miss(dec_miss),
    .stat_valid(stat_valid), .stat_accept(stat_accept), .stat_long(stat_long),
    .stat_miss(stat_miss), .babble_irq(babble_irq)
  );

  int n_chk = 0, n_fail = 0;
  bit c_rej, c_prom, c_drt, c_loop;
  int c_max;
  int r_dec_n, r_dec_at, r_dec_acc, r_dec_miss, r_irq_n, r_irq_at;
  int r_st_n, r_st_at, r_st_acc, r_st_long, r_st_miss;

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic configure(input bit p, input bit rej, input bit drt, input bit lp, input int mx);
    @(negedge clk);
    enable = 1'b0;
    cfg_promisc = p; cfg_bc_reject = rej; cfg_no_rx_on_tx = drt; cfg_loopback = lp;
    cfg_max_len = LEN_W'(mx);
    c_prom = p; c_rej = rej; c_drt = drt; c_loop = lp; c_max = mx;
    @(negedge clk);
    @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic observe(input int k);
    if (dec_valid) begin r_dec_n++; r_dec_at = k; r_dec_acc = dec_accept; r_dec_miss = dec_miss; end
    if (babble_irq) begin r_irq_n++; r_irq_at = k; end
    if (stat_valid) begin
      r_st_n++; r_st_at = k; r_st_acc = stat_accept; r_st_long = stat_long; r_st_miss = stat_miss;
    end
  endtask

  task automatic send_frame(input logic [47:0] da, input int len, input bit tx);
    r_dec_n = 0; r_dec_at = -1; r_dec_acc = 0; r_dec_miss = 0; r_irq_n = 0; r_irq_at = -1;
    r_st_n = 0; r_st_at = -1; r_st_acc = 0; r_st_long = 0; r_st_miss = 0;
    for (int k = 0; k <= len + 2; k++) begin
      @(negedge clk);
      if (k > 0) observe(k);
      if (k < len) begin
        in_valid = 1'b1; in_sof = (k == 0); in_eof = (k == len - 1);
        in_data = (k < AB) ? da[47-8*k -: 8] : 8'(k * 7 + 3);
        tx_active = tx;
      end else begin
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; tx_active = 1'b0;
      end
    end
  endtask

  task automatic verify(input logic [47:0] da, input int len, input bit tx, input string force_tag);
    bit blocked, hit, bc, normal, acc, miss, lng;
    string t;
    blocked = c_drt && !c_loop && tx;
    hit = (da == STATION); bc = (da == BCAST);
    normal = hit || (bc && !c_rej);
    acc = !blocked && (len >= AB) && (c_prom || normal);
    miss = acc && c_prom && !normal;
    lng = !blocked && (len > c_max);
    if (force_tag != "") t = force_tag;
    else if (blocked) t = "R9";
    else if (c_drt && c_loop && tx) t = "R10";
    else if (len < AB) t = "R11";
    else if (c_prom) t = "R7";
    else if (bc) t = "R6";
    else if (!hit && da[40]) t = "R8";
    else t = "R5";
    check_eq({t, " status accept"}, r_st_acc, int'(acc));
    check_eq({t, " status miss"}, r_st_miss, int'(miss));
    check_eq({t, " verdict accept"}, r_dec_acc, int'(acc));
    check_eq({t, " verdict miss"}, r_dec_miss, int'(miss));
    check_eq("R11 verdict count", r_dec_n, 1);
    check_eq("R11 verdict byte", r_dec_at, (len < AB) ? len : AB);
    check_eq("R12 status count", r_st_n, 1);
    check_eq("R12 status byte", r_st_at, len);
    check_eq("R4 status long", r_st_long, int'(lng));
    check_eq("R4 irq count", r_irq_n, int'(lng));
    if (lng) check_eq("R4 irq byte", r_irq_at, c_max + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [47:0] da;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    check_eq("R1 dec_valid", dec_valid, 0);
    check_eq("R1 dec_accept", dec_accept, 0);
    check_eq("R1 dec_miss", dec_miss, 0);
    check_eq("R1 stat_valid", stat_valid, 0);
    check_eq("R1 stat_accept", stat_accept, 0);
    check_eq("R1 stat_long", stat_long, 0);
    check_eq("R1 stat_miss", stat_miss, 0);
    check_eq("R1 babble_irq", babble_irq, 0);

    // policy sweep over all mode bits, tx state and address kinds
    for (int m = 0; m < 16; m++) begin
      configure(m[0], m[1], m[2], m[3], 12);
      for (int tx = 0; tx < 2; tx++)
        for (int kind = 0; kind < 4; kind++) begin
          da = (kind == 0) ? STATION : (kind == 1) ? BCAST : (kind == 2) ? GROUP : OTHER;
          send_frame(da, 8, tx[0]);
          verify(da, 8, tx[0], "");
        end
    end

    // length sweep around the limit, including short frames
    configure(0, 0, 0, 0, 12);
    for (int len = 1; len <= 16; len++) begin
      send_frame(STATION, len, 1'b0);
      verify(STATION, len, 1'b0, "");
    end

    // R3: stray bytes outside a frame are ignored
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (k == 2); in_data = 8'hFF;
    end
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check_eq("R3 stray verdict", dec_valid, 0);
      check_eq("R3 stray status", stat_valid, 0);
      check_eq("R3 stray irq", babble_irq, 0);
      @(negedge clk);
    end
    send_frame(STATION, 13, 1'b0);
    verify(STATION, 13, 1'b0, "R3");

    // R2: changes while enabled are not seen
    cfg_promisc = 1'b1;
    cfg_max_len = LEN_W'(3);
    send_frame(OTHER, 8, 1'b0);
    verify(OTHER, 8, 1'b0, "R2");
    send_frame(GROUP, 10, 1'b0);
    verify(GROUP, 10, 1'b0, "R2");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule